// File: doc/BRIEF.md
# Flash Program Staging Buffer

This block collects the bytes of one flash programming chunk before the program sequencer writes them into the array. Software first sets the target flash address, then returns the fill pointer to zero, then pushes data through a narrow data register. Each push packs its strobed byte lanes into the buffer at the fill pointer. The pointer then moves forward by the number of bytes actually kept.

The buffer never holds more bytes than fit between the current flash address and the next 32-byte-aligned boundary. Bytes beyond that room are discarded and raise a sticky overflow flag. Byte positions that were never written present 0xFF, so those flash cells stay in the erased state.

When the sequencer reports a finished program operation, the flash address moves forward by the fill count. A long image can therefore be programmed chunk after chunk without reloading the address. While the sequencer reports busy, every register write is ignored.

Top module: `prog_stage_buf`

## Requirements
- R1: After synchronous reset, flash_addr is 0, fill_count is 0, stage_valid is all zero, every stage_data byte is 0xFF, overflow is 0 and rd_data is 0.
- R2: An accepted write to offset 0x20 loads flash_addr from wr_data[ADDR_W-1:0].
- R3: An accepted write to offset 0x24 takes the strobed byte lanes in ascending lane order. It stores them at buffer positions fill_count, fill_count+1 and onward, and raises fill_count by the number of bytes stored. Any strobe pattern is allowed, including non-contiguous ones.
- R4: An accepted write to offset 0x28, whatever its data, sets fill_count to 0, clears stage_valid, returns every buffer byte to 0xFF and clears overflow.
- R5: A byte is stored only if its position is below 32 minus flash_addr[4:0]. Each byte that does not fit is dropped and sets overflow. Overflow stays set until the next R4 write.
- R6: A buffer byte not written since the last clear reads 0xFF on stage_data, and its stage_valid bit is 0. A written byte has its stage_valid bit at 1.
- R7: A prog_done pulse adds the fill count from before that edge to flash_addr, modulo 2^ADDR_W. An address load accepted in the same cycle takes precedence.
- R8: While busy is high, writes to every offset are ignored.
- R9: A read with rd_en returns its result on rd_data one cycle later. Offset 0x20 returns flash_addr, 0x28 returns fill_count, and 0x2C returns overflow in bit 0 and busy in bit 1. Any other offset returns 0. rd_data holds its value when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| wr_ofs | input | 6 | Register write offset |
| wr_data | input | 8*DATA_BYTES | Register write data |
| wr_strb | input | DATA_BYTES | Byte lane strobes for data pushes |
| rd_en | input | 1 | Register read request |
| rd_ofs | input | 6 | Register read offset |
| rd_data | output | 8*DATA_BYTES | Registered read result |
| busy | input | 1 | Sequencer is running a program operation |
| prog_done | input | 1 | One-cycle pulse at the end of a program operation |
| flash_addr | output | ADDR_W | Flash address of the next chunk |
| fill_count | output | $clog2(BUF_BYTES)+1 | Bytes staged so far |
| stage_data | output | 8*BUF_BYTES | Buffer contents, byte j at bits 8j+7..8j |
| stage_valid | output | BUF_BYTES | One bit per staged byte |
| overflow | output | 1 | Sticky flag for dropped bytes |

## Verification
The hardest case to reach is a push that straddles the room limit. For that, the flash address must sit a few bytes below an aligned boundary while the fill pointer already holds data, so that some lanes of one push are kept and the rest are dropped. The stimulus loads an address with low bits 29 and pushes a full word, pushes again once the buffer is full, and repeats the fill-to-32 case with an aligned address. It also overlaps a push and a prog_done, and issues writes while busy, to show which edge value each update uses.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int unsigned OFS_W = 6;
  localparam logic [OFS_W-1:0] OFS_ADDR  = 6'h20;
  localparam logic [OFS_W-1:0] OFS_DATA  = 6'h24;
  localparam logic [OFS_W-1:0] OFS_INDEX = 6'h28;
  localparam logic [OFS_W-1:0] OFS_STAT  = 6'h2C;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_ADDR  = 2'd1,
    ACC_DATA  = 2'd2,
    ACC_INDEX = 2'd3
  } acc_e;
endpackage

// File: rtl/psb_regif.sv
module psb_regif
  import psb_pkg::*;
(
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic             busy,
  output acc_e             acc
);
  always_comb begin
    acc = ACC_NONE;
    if (wr_en && !busy) begin
      unique case (wr_ofs)
        OFS_ADDR:  acc = ACC_ADDR;
        OFS_DATA:  acc = ACC_DATA;
        OFS_INDEX: acc = ACC_INDEX;
        default:   acc = ACC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/psb_addr.sv
module psb_addr #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned IW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic [IW-1:0]     adv_by,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] step;
  assign step = {{(ADDR_W-IW){1'b0}}, adv_by};

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (adv)  addr_q <= addr_q + step;
  end
endmodule

// File: rtl/psb_stage.sv
module psb_stage #(
  parameter int unsigned BUF_BYTES  = 32,
  parameter int unsigned DATA_BYTES = 4,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned IW = AW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    wr,
  input  logic [DATA_BYTES-1:0]   strb,
  input  logic [8*DATA_BYTES-1:0] wdata,
  input  logic [AW-1:0]           base_lo,
  output logic [8*BUF_BYTES-1:0]  data_flat,
  output logic [BUF_BYTES-1:0]    valid,
  output logic [IW-1:0]           idx_q,
  output logic                    ovf_q
);
  logic [IW-1:0]   room;
  logic [IW:0]     tgt [DATA_BYTES];
  logic [DATA_BYTES-1:0] take;
  logic [IW-1:0]   n_take;
  logic            any_drop;
  logic [IW:0]     run;

  assign room = IW'(BUF_BYTES) - {1'b0, base_lo};

  // Pack strobed lanes in ascending order; each lane either fits or drops.
  always_comb begin
    run      = {1'b0, idx_q};
    take     = '0;
    n_take   = '0;
    any_drop = 1'b0;
    for (int l = 0; l < DATA_BYTES; l++) begin
      tgt[l] = run;
      if (strb[l]) begin
        if (run < {1'b0, room}) begin
          take[l] = 1'b1;
          n_take  = n_take + IW'(1);
        end else begin
          any_drop = 1'b1;
        end
        run = run + (IW+1)'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q <= '0;
      ovf_q <= 1'b0;
    end else if (wr) begin
      idx_q <= idx_q + n_take;
      if (any_drop) ovf_q <= 1'b1;
    end
  end

  for (genvar j = 0; j < BUF_BYTES; j++) begin : g_byte
    logic       hit;
    logic [7:0] nxt;
    logic [7:0] mem_q;
    logic       vld_q;

    always_comb begin
      hit = 1'b0;
      nxt = 8'hFF;
      for (int l = 0; l < DATA_BYTES; l++) begin
        if (take[l] && tgt[l] == (IW+1)'(j)) begin
          hit = 1'b1;
          nxt = wdata[8*l +: 8];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        mem_q <= 8'hFF;
        vld_q <= 1'b0;
      end else if (wr && hit) begin
        mem_q <= nxt;
        vld_q <= 1'b1;
      end
    end

    assign data_flat[8*j +: 8] = mem_q;
    assign valid[j]            = vld_q;
  end
endmodule

// File: rtl/prog_stage_buf.sv
module prog_stage_buf
  import psb_pkg::*;
#(
  parameter int unsigned BUF_BYTES  = 32,
  parameter int unsigned DATA_BYTES = 4,
  parameter int unsigned ADDR_W     = 20,
  localparam int unsigned DW = 8*DATA_BYTES,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned IW = AW + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [OFS_W-1:0]       wr_ofs,
  input  logic [DW-1:0]          wr_data,
  input  logic [DATA_BYTES-1:0]  wr_strb,
  input  logic                   rd_en,
  input  logic [OFS_W-1:0]       rd_ofs,
  output logic [DW-1:0]          rd_data,
  input  logic                   busy,
  input  logic                   prog_done,
  output logic [ADDR_W-1:0]      flash_addr,
  output logic [IW-1:0]          fill_count,
  output logic [8*BUF_BYTES-1:0] stage_data,
  output logic [BUF_BYTES-1:0]   stage_valid,
  output logic                   overflow
);
  acc_e acc;

  psb_regif u_regif (
    .wr_en  (wr_en),
    .wr_ofs (wr_ofs),
    .busy   (busy),
    .acc    (acc)
  );

  psb_addr #(.ADDR_W(ADDR_W), .IW(IW)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (acc == ACC_ADDR),
    .load_val (wr_data[ADDR_W-1:0]),
    .adv      (prog_done),
    .adv_by   (fill_count),
    .addr_q   (flash_addr)
  );

  psb_stage #(.BUF_BYTES(BUF_BYTES), .DATA_BYTES(DATA_BYTES)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .clear     (acc == ACC_INDEX),
    .wr        (acc == ACC_DATA),
    .strb      (wr_strb),
    .wdata     (wr_data),
    .base_lo   (flash_addr[AW-1:0]),
    .data_flat (stage_data),
    .valid     (stage_valid),
    .idx_q     (fill_count),
    .ovf_q     (overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (rd_ofs)
        OFS_ADDR:  rd_data <= DW'(flash_addr);
        OFS_INDEX: rd_data <= DW'(fill_count);
        OFS_STAT:  rd_data <= DW'({busy, overflow});
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/prog_stage_buf_chk.sv
module prog_stage_buf_chk
  import psb_pkg::*;
#(
  parameter int unsigned BUF_BYTES  = 32,
  parameter int unsigned ADDR_W     = 20,
  localparam int unsigned IW = $clog2(BUF_BYTES) + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [OFS_W-1:0]     wr_ofs,
  input logic                 busy,
  input logic                 prog_done,
  input logic [ADDR_W-1:0]    flash_addr,
  input logic [IW-1:0]        fill_count,
  input logic [BUF_BYTES-1:0] stage_valid,
  input logic                 overflow
);
  logic clr_ok, ld_ok;
  assign clr_ok = wr_en && !busy && wr_ofs == OFS_INDEX;
  assign ld_ok  = wr_en && !busy && wr_ofs == OFS_ADDR;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_count <= IW'(BUF_BYTES)); // R5
  AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (rst)
    $countones(stage_valid) == int'(fill_count)); // R6
  AST_INDEX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_ok |=> fill_count == '0 && stage_valid == '0 && !overflow); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow && !clr_ok |=> overflow); // R5
  AST_DONE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    prog_done && !ld_ok |=> flash_addr == $past(flash_addr) + ADDR_W'($past(fill_count))); // R7
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    busy && !prog_done |=> $stable(flash_addr) && $stable(fill_count) && $stable(stage_valid)); // R8
endmodule

bind prog_stage_buf prog_stage_buf_chk #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/prog_stage_buf_test.sv
module prog_stage_buf_test;
  localparam int NB = 32;
  localparam int DB = 4;
  localparam int AWD = 20;

  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0;
  logic [5:0] wr_ofs = 0;
  logic [31:0] wr_data = 0;
  logic [3:0] wr_strb = 0;
  logic rd_en = 0;
  logic [5:0] rd_ofs = 0;
  logic [31:0] rd_data;
  logic busy = 0;
  logic prog_done = 0;
  logic [AWD-1:0] flash_addr;
  logic [5:0] fill_count;
  logic [8*NB-1:0] stage_data;
  logic [NB-1:0] stage_valid;
  logic overflow;

  always #10 clk = ~clk;

  prog_stage_buf uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .wr_strb(wr_strb), .rd_en(rd_en), .rd_ofs(rd_ofs), .rd_data(rd_data),
    .busy(busy), .prog_done(prog_done), .flash_addr(flash_addr),
    .fill_count(fill_count), .stage_data(stage_data), .stage_valid(stage_valid),
    .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int m_addr, m_idx;
  int m_buf[NB];
  bit m_val[NB];
  bit m_ovf;
  int m_rd;

  function automatic void model_reset();
    m_addr = 0; m_idx = 0; m_ovf = 0; m_rd = 0;
    for (int j = 0; j < NB; j++) begin m_buf[j] = 'hFF; m_val[j] = 0; end
  endfunction

  function automatic void model_step();
    int o_addr, o_idx, room;
    bit ld;
    if (rst) begin model_reset(); return; end
    o_addr = m_addr; o_idx = m_idx; ld = 0;
    if (rd_en) begin
      if (rd_ofs == 6'h20) m_rd = o_addr;
      else if (rd_ofs == 6'h28) m_rd = o_idx;
      else if (rd_ofs == 6'h2C) m_rd = (busy ? 2 : 0) + (m_ovf ? 1 : 0);
      else m_rd = 0;
    end
    if (wr_en && !busy) begin
      if (wr_ofs == 6'h20) begin
        m_addr = int'(wr_data) & ((1 << AWD) - 1); ld = 1;
      end else if (wr_ofs == 6'h28) begin
        m_idx = 0; m_ovf = 0;
        for (int j = 0; j < NB; j++) begin m_buf[j] = 'hFF; m_val[j] = 0; end
      end else if (wr_ofs == 6'h24) begin
        room = NB - (o_addr % NB);
        for (int l = 0; l < DB; l++) begin
          if (wr_strb[l]) begin
            if (m_idx < room) begin
              m_buf[m_idx] = int'(wr_data[8*l +: 8]); m_val[m_idx] = 1; m_idx++;
            end else m_ovf = 1;
          end
        end
      end
    end
    if (prog_done && !ld) m_addr = (o_addr + o_idx) & ((1 << AWD) - 1);
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("flash_addr", int'(flash_addr), m_addr);
    chk("fill_count", int'(fill_count), m_idx);
    chk("overflow", int'(overflow), int'(m_ovf));
    chk("rd_data", int'(rd_data), m_rd);
    for (int j = 0; j < NB; j++) begin
      chk($sformatf("stage_data[%0d]", j), int'(stage_data[8*j +: 8]), m_buf[j]);
      chk($sformatf("stage_valid[%0d]", j), int'(stage_valid[j]), int'(m_val[j]));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [5:0] ofs, logic [31:0] d, logic [3:0] s);
    wr_en = 1; wr_ofs = ofs; wr_data = d; wr_strb = s;
    tick();
    wr_en = 0; wr_strb = 0;
  endtask

  task automatic rd(logic [5:0] ofs);
    rd_en = 1; rd_ofs = ofs;
    tick();
    rd_en = 0;
  endtask

  task automatic done_pulse();
    prog_done = 1;
    tick();
    prog_done = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    cur_req = "R1"; tick();
    rst = 0;
    tick();

    cur_req = "R2"; wr(6'h20, 32'h0000_0100, 4'h0);
    cur_req = "R3"; wr(6'h24, 32'h4433_2211, 4'hF);
    wr(6'h24, 32'h0000_BBAA, 4'h3);
    wr(6'h24, 32'h00CC_0000, 4'h4);
    cur_req = "R3 sparse"; wr(6'h24, 32'hEE00_DD00, 4'hA);
    cur_req = "R6"; tick();
    cur_req = "R9"; rd(6'h28); tick(); rd(6'h20); rd(6'h24); rd(6'h3C);

    cur_req = "R8"; busy = 1;
    wr(6'h24, 32'h1234_5678, 4'hF);
    wr(6'h28, 32'h0, 4'h0);
    wr(6'h20, 32'h0000_0777, 4'h0);
    rd(6'h2C);
    cur_req = "R7"; done_pulse();
    busy = 0; tick();

    cur_req = "R4"; wr(6'h28, 32'hFFFF_FFFF, 4'h0);
    cur_req = "R5"; wr(6'h20, 32'h0000_011D, 4'h0);
    wr(6'h24, 32'h8877_6655, 4'hF);
    rd(6'h2C);
    wr(6'h24, 32'h0000_0099, 4'h1);
    tick();
    cur_req = "R4"; wr(6'h28, 32'h0, 4'h0);

    cur_req = "R5 full"; wr(6'h20, 32'h0000_0200, 4'h0);
    for (int k = 0; k < 8; k++) wr(6'h24, 32'h0101_0101 * (k + 1), 4'hF);
    wr(6'h24, 32'hDEAD_BEEF, 4'hF);
    rd(6'h2C);
    cur_req = "R7 overlap"; wr(6'h28, 32'h0, 4'h0);
    wr(6'h24, 32'h0000_3030, 4'h3);
    prog_done = 1; wr_en = 1; wr_ofs = 6'h24; wr_data = 32'h0000_0040; wr_strb = 4'h1;
    tick();
    prog_done = 0; wr_en = 0; wr_strb = 0;
    cur_req = "R7 addr wins"; prog_done = 1;
    wr(6'h20, 32'h000F_FFFF, 4'h0);
    prog_done = 0;
    cur_req = "R7 wrap"; done_pulse();
    rd(6'h20); tick();

    summary();
    $finish;
  end
endmodule